// File: doc/BRIEF.md
# GPIO Interrupt Detect and Status Banks

This block turns a set of general-purpose input pins into per-pin interrupt status and one combined interrupt request. Each pin has its own trigger selection. One bit picks edge or level sensing and a second bit inverts the polarity, which gives four modes: rising edge, falling edge, level low and level high. A pin only takes part when its input sensing is on and it is in general-purpose mode. The pin inputs must already be synchronized to `clk_i`.

Status and enable bits are grouped into 32-bit words, one word per bank of 32 pins. Software reads both words through a small register port. It clears status by writing ones, and it writes enable words whole. A status bit records events whatever its enable is. The enable only decides whether that bit feeds the registered interrupt output. An event that arrives in the same cycle as a clear of its bit wins, so no edge is lost.

Top module: `gpio_irq_banks`

## Requirements
- R1: Trigger code {level,invert} = 00 detects rising edges. The status bit is set at the clock edge where the pin is 1 and was 0 at the previous edge. The pin history resets to 0.
- R2: Trigger code 01 detects falling edges. The status bit is set at the clock edge where the pin is 0 and was 1 at the previous edge.
- R3: Trigger code 10 sets the status bit at every clock edge where the pin is 0. Trigger code 11 sets it at every edge where the pin is 1. While the active level stays present, the bit is set again straight after a clear.
- R4: A write to a status word (address bit 2 = 0) clears exactly the bits written as 1 and leaves the others unchanged. Writing 0xFFFFFFFF clears the whole bank.
- R5: If a trigger event and a clear of the same bit happen at the same clock edge, the bit stays set.
- R6: A pin whose sensing enable is 0, or whose mode input is 0 (native function), never sets its status bit.
- R7: Status bits are set whatever their enable bit is. Writing an enable word (address bit 2 = 1) replaces that bank's enable bits and leaves status unchanged.
- R8: `irq_o` is a register. At each clock edge it loads the OR, over all banks, of status AND enable as they stood before that edge. It therefore trails a change in status or enable by one cycle.
- R9: After reset all status bits, all enable bits and `irq_o` are 0. Bits for pins at or beyond NUM_PINS read 0 and cannot be set. A bank index at or beyond the bank count reads 0 and ignores writes.
- R10: Pin p sits at bit p%32 of bank p/32. Address bits [1:0] hold the bank index and bit 2 selects status (0) or enable (1). Read data is combinational from the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | NUM_PINS | Synchronized pin levels |
| trig_lvl_i | input | NUM_PINS | Per pin: 0 edge, 1 level |
| trig_inv_i | input | NUM_PINS | Per pin polarity invert |
| sense_en_i | input | NUM_PINS | Per pin input sensing enable |
| gpio_mode_i | input | NUM_PINS | Per pin: 1 general-purpose, 0 native |
| reg_addr_i | input | ADDR_W | Word address: {select, bank index} |
| reg_we_i | input | 1 | Write strobe |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i |
| irq_o | output | 1 | Combined registered interrupt request |

## Verification
The rising and falling modes are driven with held levels and with steps in both directions. This shows that an edge pin reacts to one transition only and never to a steady level. Level pins are held while their status is cleared, which separates level sensing (the bit sets again) from edge sensing (the bit stays clear). A pin edge placed in the same cycle as a write-one-to-clear checks that the event wins, while a neighbouring bit in that write is still cleared. Pins that are muted, pins in the upper banks, nonexistent pins, and a long random stream of toggles, mode changes, clears and enable writes check the bank and bit layout and the one-cycle delay of `irq_o`.

// File: rtl/gpio_irq_pkg.sv
`timescale 1ns/1ps
package gpio_irq_pkg;

  localparam int unsigned BANK_W = 32;

  // {level, invert}
  typedef enum logic [1:0] {
    TRIG_RISE = 2'b00,
    TRIG_FALL = 2'b01,
    TRIG_LOW  = 2'b10,
    TRIG_HIGH = 2'b11
  } trig_e;

  typedef enum logic {
    REG_STATUS = 1'b0,
    REG_ENABLE = 1'b1
  } reg_sel_e;

  function automatic int unsigned bank_valid(input int unsigned n_pins,
                                             input int unsigned bank);
    int unsigned base;
    base = bank * BANK_W;
    if (n_pins <= base) return 0;
    if (n_pins - base >= BANK_W) return BANK_W;
    return n_pins - base;
  endfunction

endpackage

// File: rtl/gpio_irq_detect.sv
`timescale 1ns/1ps
module gpio_irq_detect
  import gpio_irq_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] pin_i,
  input  logic [W-1:0] lvl_i,
  input  logic [W-1:0] inv_i,
  input  logic [W-1:0] act_i,
  output logic [W-1:0] evt_o
);

  logic [W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= pin_i;
  end

  for (genvar p = 0; p < W; p++) begin : g_pin
    trig_e mode;
    logic  hit;
    assign mode = trig_e'({lvl_i[p], inv_i[p]});
    always_comb begin
      unique case (mode)
        TRIG_RISE: hit =  pin_i[p] & ~prev_q[p];
        TRIG_FALL: hit = ~pin_i[p] &  prev_q[p];
        TRIG_LOW:  hit = ~pin_i[p];
        default:   hit =  pin_i[p];
      endcase
    end
    assign evt_o[p] = hit & act_i[p];
  end

  // edge modes fire only when the pin moved since the last edge
  AST_EDGE_NEEDS_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((evt_o & ~lvl_i & ~(pin_i ^ prev_q)) == '0)); // R1

endmodule

// File: rtl/gpio_irq_bank.sv
`timescale 1ns/1ps
module gpio_irq_bank
  import gpio_irq_pkg::*;
#(
  parameter int unsigned VALID = BANK_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BANK_W-1:0] evt_i,
  input  logic [BANK_W-1:0] clr_i,
  input  logic              en_we_i,
  input  logic [BANK_W-1:0] en_wdata_i,
  output logic [BANK_W-1:0] status_o,
  output logic [BANK_W-1:0] enable_o,
  output logic              pend_o
);

  localparam logic [BANK_W-1:0] MASK = (VALID >= BANK_W) ? {BANK_W{1'b1}} :
                                       BANK_W'((64'd1 << VALID) - 64'd1);

  logic [BANK_W-1:0] status_q, status_d;
  logic [BANK_W-1:0] enable_q, enable_d;

  // set dominates clear: a concurrent event survives the W1C
  assign status_d = ((status_q & ~clr_i) | evt_i) & MASK;
  assign enable_d = en_we_i ? (en_wdata_i & MASK) : enable_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= '0;
      enable_q <= '0;
    end else begin
      status_q <= status_d;
      enable_q <= enable_d;
    end
  end

  assign status_o = status_q;
  assign enable_o = enable_q;
  assign pend_o   = |(status_q & enable_q);

  AST_EVENT_BEATS_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|evt_i) |=> ((status_q & $past(evt_i & MASK)) == $past(evt_i & MASK))); // R5

  AST_CLEAR_ONLY_WRITTEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(status_q) & ~$past(clr_i) & ~status_q) == '0)); // R4

  AST_NO_PHANTOM_BITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (((status_q | enable_q) & ~MASK) == '0)); // R9

endmodule

// File: rtl/gpio_irq_banks.sv
`timescale 1ns/1ps
module gpio_irq_banks
  import gpio_irq_pkg::*;
#(
  parameter  int unsigned NUM_PINS  = 94,
  localparam int unsigned NUM_BANKS = (NUM_PINS + BANK_W - 1) / BANK_W,
  localparam int unsigned IDX_W     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int unsigned ADDR_W    = IDX_W + 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pin_i,
  input  logic [NUM_PINS-1:0] trig_lvl_i,
  input  logic [NUM_PINS-1:0] trig_inv_i,
  input  logic [NUM_PINS-1:0] sense_en_i,
  input  logic [NUM_PINS-1:0] gpio_mode_i,
  input  logic [ADDR_W-1:0]   reg_addr_i,
  input  logic                reg_we_i,
  input  logic [BANK_W-1:0]   reg_wdata_i,
  output logic [BANK_W-1:0]   reg_rdata_o,
  output logic                irq_o
);

  localparam int unsigned PAD_W = NUM_BANKS * BANK_W;

  logic [PAD_W-1:0] pin_pad, lvl_pad, inv_pad, act_pad, evt_w;
  logic [PAD_W-1:0] status_all, enable_all;
  logic [NUM_BANKS-1:0] pend_w;

  assign pin_pad = PAD_W'(pin_i);
  assign lvl_pad = PAD_W'(trig_lvl_i);
  assign inv_pad = PAD_W'(trig_inv_i);
  assign act_pad = PAD_W'(sense_en_i & gpio_mode_i);

  gpio_irq_detect #(.W(PAD_W)) u_detect (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (pin_pad),
    .lvl_i  (lvl_pad),
    .inv_i  (inv_pad),
    .act_i  (act_pad),
    .evt_o  (evt_w)
  );

  logic [IDX_W-1:0] idx_w;
  reg_sel_e         sel_w;
  assign idx_w = reg_addr_i[IDX_W-1:0];
  assign sel_w = reg_sel_e'(reg_addr_i[ADDR_W-1]);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic              hit;
    logic [BANK_W-1:0] clr;
    assign hit = reg_we_i && (idx_w == IDX_W'(b));
    assign clr = (hit && sel_w == REG_STATUS) ? reg_wdata_i : '0;

    gpio_irq_bank #(.VALID(bank_valid(NUM_PINS, b))) u_bank (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .evt_i      (evt_w[b*BANK_W +: BANK_W]),
      .clr_i      (clr),
      .en_we_i    (hit && sel_w == REG_ENABLE),
      .en_wdata_i (reg_wdata_i),
      .status_o   (status_all[b*BANK_W +: BANK_W]),
      .enable_o   (enable_all[b*BANK_W +: BANK_W]),
      .pend_o     (pend_w[b])
    );
  end

  always_comb begin
    reg_rdata_o = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (idx_w == IDX_W'(b)) begin
        reg_rdata_o = (sel_w == REG_ENABLE) ? enable_all[b*BANK_W +: BANK_W]
                                            : status_all[b*BANK_W +: BANK_W];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else         irq_o <= |pend_w;
  end

  logic [PAD_W-1:0] hi_w;
  assign hi_w = pin_pad & lvl_pad & inv_pad & act_pad;

  AST_IRQ_RISE_PENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(|pend_w)); // R8

  AST_LEVEL_HIGH_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((status_all & $past(hi_w)) == $past(hi_w))); // R3

  AST_MUTED_NO_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((status_all & ~$past(status_all) & ~$past(act_pad)) == '0)); // R6

endmodule

// File: tb/gpio_irq_banks_bench.sv
`timescale 1ns/1ps
module gpio_irq_banks_bench;

  localparam int NP = 94;
  localparam int NB = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [NP-1:0] pin = '0, lvl = '0, inv = '0, sense = '0, gmode = '0;
  logic [2:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;
  bit cmp_on = 0;
  string cur_req = "R9";

  always #2.5 clk = ~clk;

  gpio_irq_banks #(.NUM_PINS(NP)) u_gpio_irq_banks (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .pin_i       (pin),
    .trig_lvl_i  (lvl),
    .trig_inv_i  (inv),
    .sense_en_i  (sense),
    .gpio_mode_i (gmode),
    .reg_addr_i  (addr),
    .reg_we_i    (we),
    .reg_wdata_i (wdata),
    .reg_rdata_o (rdata),
    .irq_o       (irq)
  );

  // behavioural reference
  bit st_m[NB*32];
  bit en_m[NB*32];
  bit prev_m[NP];
  bit irq_m;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (st_m[i]) begin st_m[i] = 0; en_m[i] = 0; end
      foreach (prev_m[i]) prev_m[i] = 0;
      irq_m = 0;
    end else begin
      bit any;
      bit ev[NB*32];
      any = 0;
      foreach (st_m[i]) if (st_m[i] && en_m[i]) any = 1;
      foreach (ev[i]) ev[i] = 0;
      for (int p = 0; p < NP; p++) begin
        if (sense[p] && gmode[p]) begin
          if (!lvl[p] && !inv[p]) ev[p] = pin[p] && !prev_m[p];
          else if (!lvl[p] && inv[p]) ev[p] = !pin[p] && prev_m[p];
          else if (lvl[p] && !inv[p]) ev[p] = !pin[p];
          else ev[p] = pin[p];
        end
      end
      for (int p = 0; p < NB*32; p++) begin
        int b;
        b = p / 32;
        if (we && addr[2] == 1'b0 && addr[1:0] == b[1:0] && wdata[p%32]) st_m[p] = 0;
        if (ev[p]) st_m[p] = 1;
        if (we && addr[2] == 1'b1 && addr[1:0] == b[1:0]) en_m[p] = (p < NP) ? wdata[p%32] : 1'b0;
      end
      for (int p = 0; p < NP; p++) prev_m[p] = pin[p];
      irq_m = any;
    end
  end

  function automatic logic [31:0] model_word(input logic [2:0] a);
    logic [31:0] w;
    w = '0;
    if (a[1:0] < NB) begin
      for (int k = 0; k < 32; k++)
        w[k] = a[2] ? en_m[a[1:0]*32 + k] : st_m[a[1:0]*32 + k];
    end
    return w;
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s act %h exp %h", req, what, act, exp);
    end
  endtask

  // cycle compare against the model, 1 ns after every edge
  always @(posedge clk) begin
    #1;
    if (cmp_on && rst_n) begin
      check(cur_req, "model rdata", rdata, model_word(addr));
      check(cur_req, "model irq", {31'd0, irq}, {31'd0, irq_m});
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input string req, input logic [2:0] a, input logic [31:0] exp);
    addr = a;
    #0.5;
    check(req, "rdata", rdata, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    rd("R9", 3'd0, 32'h0);
    rd("R9", 3'd2, 32'h0);
    rd("R9", 3'd4, 32'h0);
    rd("R9", 3'd6, 32'h0);
    check("R9", "irq reset", {31'd0, irq}, 32'd0);
    rst_n = 1'b1;
    cmp_on = 1;
    idle(1);

    // modes: p0 rise, p1 fall, p2 low, p3 high, p5 sense off, p6 native, p40/p93 rise
    cur_req = "R3";
    sense[9:0] = 10'h3DF; gmode[9:0] = 10'h3BF;
    sense[40] = 1; gmode[40] = 1; sense[93] = 1; gmode[93] = 1;
    lvl[1:0] = 2'b00; inv[1:0] = 2'b10;
    lvl[3:2] = 2'b11; inv[3:2] = 2'b10;
    idle(2);
    rd("R3", 3'd0, 32'h4);
    wr(3'd0, 32'hFFFF_FFFF);
    rd("R3", 3'd0, 32'h4);
    pin[2] = 1;
    idle(1);
    wr(3'd0, 32'hFFFF_FFFF);
    rd("R4", 3'd0, 32'h0);

    // R1 rising, R3 level high, R6 muted pins
    cur_req = "R1";
    pin[0] = 1; pin[3] = 1; pin[5] = 1; pin[6] = 1;
    idle(1);
    rd("R1", 3'd0, 32'h9);
    idle(2);
    rd("R6", 3'd0, 32'h9);
    pin[3] = 0;
    wr(3'd0, 32'hFFFF_FFFF);
    rd("R4", 3'd0, 32'h0);

    // R2 falling
    cur_req = "R2";
    pin[1] = 1;
    idle(2);
    rd("R2", 3'd0, 32'h0);
    pin[1] = 0;
    idle(1);
    rd("R2", 3'd0, 32'h2);

    // R4 partial W1C
    cur_req = "R4";
    pin[0] = 0;
    idle(1);
    pin[0] = 1;
    idle(1);
    rd("R4", 3'd0, 32'h3);
    wr(3'd0, 32'h1);
    rd("R4", 3'd0, 32'h2);
    wr(3'd0, 32'h0);
    rd("R4", 3'd0, 32'h2);

    // R5 edge in the clearing cycle
    cur_req = "R5";
    @(negedge clk); pin[0] = 0;
    @(negedge clk); pin[0] = 1; addr = 3'd0; wdata = 32'h3; we = 1'b1;
    @(negedge clk); we = 1'b0;
    rd("R5", 3'd0, 32'h1);

    // R7 status without enable, R8 registered irq
    cur_req = "R7";
    idle(3);
    check("R7", "irq masked", {31'd0, irq}, 32'd0);
    rd("R7", 3'd0, 32'h1);
    cur_req = "R8";
    wr(3'd4, 32'h1);
    check("R8", "irq lag", {31'd0, irq}, 32'd0);
    rd("R7", 3'd0, 32'h1);
    @(negedge clk);
    check("R8", "irq set", {31'd0, irq}, 32'd1);
    wr(3'd0, 32'h1);
    check("R8", "irq hold", {31'd0, irq}, 32'd1);
    @(negedge clk);
    check("R8", "irq drop", {31'd0, irq}, 32'd0);

    // R10 layout, R9 phantom bits
    cur_req = "R10";
    pin[40] = 1; pin[93] = 1;
    idle(1);
    rd("R10", 3'd1, 32'h0000_0100);
    rd("R10", 3'd2, 32'h2000_0000);
    cur_req = "R9";
    wr(3'd6, 32'hFFFF_FFFF);
    rd("R9", 3'd6, 32'h3FFF_FFFF);
    wr(3'd3, 32'hFFFF_FFFF);
    rd("R9", 3'd3, 32'h0);
    wr(3'd7, 32'hFFFF_FFFF);
    rd("R9", 3'd7, 32'h0);
    rd("R9", 3'd4, 32'h1);

    // random traffic against the model
    cur_req = "R8";
    for (int c = 0; c < 3000; c++) begin
      @(negedge clk);
      if (c % 200 == 0) begin
        for (int p = 0; p < NP; p++) begin
          sense[p] = ($urandom % 8) != 0;
          gmode[p] = ($urandom % 8) != 0;
          lvl[p] = $urandom % 2;
          inv[p] = $urandom % 2;
        end
      end
      for (int p = 0; p < NP; p++) if ($urandom % 16 == 0) pin[p] = ~pin[p];
      addr = 3'($urandom);
      we = ($urandom % 4) == 0;
      wdata = $urandom;
    end
    @(negedge clk);
    we = 1'b0;
    idle(2);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog R8 act hung exp done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule